// File: doc/BRIEF.md
# Banked Sharer-Vector Coherence Directory

This block keeps, for every line address of a small physical space, a record of which private second-level caches hold a copy. Each record has a state (Invalid, Shared or Modified) and one presence bit per cache. A cache consults the directory only after it misses in its own L2. It sends a read-shared or a read-exclusive request. The directory looks up the record and decides what to do. If no other cache holds the line, it grants the request at once and sends no coherence traffic. Otherwise it sends one probe, multicast only to the caches whose presence bits are set. It then waits until every probed cache has acknowledged, rewrites the record and returns a grant to the requester.

The records are split over several banks, selected by the low bits of the line address. Each bank works on one transaction at a time and has its own busy flag. A request that maps to a busy bank is held off with backpressure, while the other banks keep accepting work. All banks share one probe port and one grant port, and fixed-priority pickers arbitrate for them.

Top module: `sharer_directory`

## Requirements
- R1: After reset every line is Invalid with an empty presence vector, `req_ready` is high and neither `prb_valid` nor `gnt_valid` is asserted.
- R2: A request (`req_excl`=0 read-shared, 1 read-exclusive) to a line that no other cache holds is granted in the cycle after acceptance, with no probe. `gnt_dst` is the requester and `gnt_excl` echoes the request type.
- R3: A read-exclusive request to a line held by other caches produces exactly one invalidate probe (`prb_kind`=0) in the cycle after acceptance. Its `prb_mask` is the recorded holders minus the requester, with bit c standing for cache c.
- R4: The grant is withheld until every probed cache has returned an acknowledgement (`ack_valid[c]` with `ack_line[c]` equal to the line). Acknowledgements from several caches in one cycle all count. The grant appears in the cycle after the edge that samples the last one.
- R5: A read-shared request to a Modified line owned by another cache sends a downgrade probe (`prb_kind`=1) to the owner alone. Afterwards both the owner and the requester are recorded as sharers.
- R6: After a read-exclusive grant the line is Modified, with the requester as its sole owner.
- R7: The bank of a line is `line[BANK_W-1:0]`. `req_ready` is low for any line of a bank that has a transaction open and stays high for lines of idle banks.
- R8: An acknowledgement whose line belongs to another bank does not count toward a waiting transaction.
- R9: When two banks are ready to grant in the same cycle, the lower-numbered bank grants first and the other grants in the next cycle.
- R10: A read-exclusive request from the only cache that holds the line is granted without any probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Bank of `req_line` can accept |
| req_src | input | SRC_W | Requesting cache |
| req_excl | input | 1 | 1 read-exclusive, 0 read-shared |
| req_line | input | LINE_W | Line address |
| prb_valid | output | 1 | Probe multicast this cycle |
| prb_kind | output | 1 | 0 invalidate, 1 downgrade |
| prb_mask | output | NCACHE | Target caches |
| prb_line | output | LINE_W | Probed line |
| ack_valid | input | NCACHE | Per-cache probe acknowledgement |
| ack_line | input | NCACHE x LINE_W | Line acknowledged by each cache |
| gnt_valid | output | 1 | Grant this cycle |
| gnt_dst | output | SRC_W | Cache receiving the grant |
| gnt_excl | output | 1 | Granted request type |
| gnt_line | output | LINE_W | Granted line |

## Verification
Two banks can finish in the same cycle and compete for the single grant port. The bench provokes this by opening exclusive requests in two banks whose lines have different sharers, then having both sharers acknowledge on one edge. It judges that the lower bank's grant shows first and the other follows one cycle later, with nothing lost. The bench also overlaps an acceptance in one bank with a pending acknowledgement wait in another, and checks that the idle bank grants while the waiting one stays closed.

// File: rtl/sharer_directory_pkg.sv
package sharer_directory_pkg;

    typedef enum logic [1:0] {
        L_INV = 2'd0,
        L_SHR = 2'd1,
        L_MOD = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        B_IDLE  = 2'd0,
        B_PROBE = 2'd1,
        B_WAIT  = 2'd2,
        B_GRANT = 2'd3
    } bank_ph_e;

    typedef enum logic {
        PK_INVAL = 1'b0,
        PK_DOWN  = 1'b1
    } probe_kind_e;

endpackage

// File: rtl/sdir_pick.sv
module sdir_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0]         req,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] idx,
    output logic                 any
);
    localparam int IDX_W = $clog2(N);

    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/sdir_bank.sv
module sdir_bank
    import sharer_directory_pkg::*;
#(
    parameter int NCACHE = 4,
    parameter int LINE_W = 6,
    parameter int BANK_W = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           acc,
    input  logic [$clog2(NCACHE)-1:0]      acc_src,
    input  logic                           acc_excl,
    input  logic [LINE_W-1:0]              acc_line,
    output logic                           busy,
    output logic                           prb_req,
    output logic [NCACHE-1:0]              prb_mask,
    output logic                           prb_kind,
    output logic [LINE_W-1:0]              prb_line,
    input  logic                           prb_take,
    input  logic [NCACHE-1:0]              ack_valid,
    input  logic [NCACHE-1:0][LINE_W-1:0]  ack_line,
    output logic                           gnt_req,
    output logic [$clog2(NCACHE)-1:0]      gnt_src,
    output logic                           gnt_excl,
    output logic [LINE_W-1:0]              gnt_line,
    input  logic                           gnt_take
);
    localparam int SRC_W = $clog2(NCACHE);
    localparam int SET_W = LINE_W - BANK_W;
    localparam int SETS  = 1 << SET_W;

    line_st_e          st_q  [SETS];
    logic [NCACHE-1:0] vec_q [SETS];

    bank_ph_e          ph_q;
    logic [LINE_W-1:0] line_q;
    logic [SRC_W-1:0]  src_q;
    logic              excl_q;
    probe_kind_e       kind_q;
    logic [NCACHE-1:0] tgt_q;
    logic [NCACHE-1:0] wait_q;
    logic [NCACHE-1:0] nvec_q;
    line_st_e          nst_q;

    logic [SET_W-1:0]  acc_idx;
    logic [SET_W-1:0]  own_idx;
    logic [NCACHE-1:0] src_bit;
    line_st_e          cur_st;
    logic [NCACHE-1:0] cur_vec;
    logic [NCACHE-1:0] tgt_d;
    probe_kind_e       kind_d;
    logic [NCACHE-1:0] nvec_d;
    line_st_e          nst_d;
    logic [NCACHE-1:0] hit;
    logic [NCACHE-1:0] left;

    assign acc_idx = acc_line[LINE_W-1:BANK_W];
    assign own_idx = line_q[LINE_W-1:BANK_W];

    // Lookup and next-record computation at acceptance
    always_comb begin
        src_bit = NCACHE'(1) << acc_src;
        cur_st  = st_q[acc_idx];
        cur_vec = vec_q[acc_idx];
        if (acc_excl) begin
            tgt_d  = cur_vec & ~src_bit;
            kind_d = PK_INVAL;
            nvec_d = src_bit;
            nst_d  = L_MOD;
        end else begin
            tgt_d  = (cur_st == L_MOD) ? (cur_vec & ~src_bit) : '0;
            kind_d = PK_DOWN;
            nvec_d = cur_vec | src_bit;
            nst_d  = L_SHR;
        end
    end

    // Acknowledgements that belong to the open line
    generate
        for (genvar c = 0; c < NCACHE; c++) begin : g_hit
            assign hit[c] = ack_valid[c] && (ack_line[c] == line_q);
        end
    endgenerate

    assign left = wait_q & ~hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= B_IDLE;
            line_q <= '0;
            src_q  <= '0;
            excl_q <= 1'b0;
            kind_q <= PK_INVAL;
            tgt_q  <= '0;
            wait_q <= '0;
            nvec_q <= '0;
            nst_q  <= L_INV;
            for (int i = 0; i < SETS; i++) begin
                st_q[i]  <= L_INV;
                vec_q[i] <= '0;
            end
        end else begin
            unique case (ph_q)
                B_IDLE: begin
                    if (acc) begin
                        line_q <= acc_line;
                        src_q  <= acc_src;
                        excl_q <= acc_excl;
                        kind_q <= kind_d;
                        tgt_q  <= tgt_d;
                        wait_q <= tgt_d;
                        nvec_q <= nvec_d;
                        nst_q  <= nst_d;
                        ph_q   <= (tgt_d != '0) ? B_PROBE : B_GRANT;
                    end
                end
                B_PROBE: begin
                    if (prb_take) ph_q <= B_WAIT;
                end
                B_WAIT: begin
                    wait_q <= left;
                    if (left == '0) ph_q <= B_GRANT;
                end
                B_GRANT: begin
                    if (gnt_take) begin
                        st_q[own_idx]  <= nst_q;
                        vec_q[own_idx] <= nvec_q;
                        ph_q           <= B_IDLE;
                    end
                end
                default: ph_q <= B_IDLE;
            endcase
        end
    end

    assign busy     = (ph_q != B_IDLE);
    assign prb_req  = (ph_q == B_PROBE);
    assign prb_mask = tgt_q;
    assign prb_kind = kind_q;
    assign prb_line = line_q;
    assign gnt_req  = (ph_q == B_GRANT);
    assign gnt_src  = src_q;
    assign gnt_excl = excl_q;
    assign gnt_line = line_q;
endmodule

// File: rtl/sharer_directory.sv
module sharer_directory
    import sharer_directory_pkg::*;
#(
    parameter int NCACHE = 4,
    parameter int NBANK  = 4,
    parameter int LINE_W = 6
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                req_valid,
    output logic                                req_ready,
    input  logic [$clog2(NCACHE)-1:0]           req_src,
    input  logic                                req_excl,
    input  logic [LINE_W-1:0]                   req_line,
    output logic                                prb_valid,
    output logic                                prb_kind,
    output logic [NCACHE-1:0]                   prb_mask,
    output logic [LINE_W-1:0]                   prb_line,
    input  logic [NCACHE-1:0]                   ack_valid,
    input  logic [NCACHE-1:0][LINE_W-1:0]       ack_line,
    output logic                                gnt_valid,
    output logic [$clog2(NCACHE)-1:0]           gnt_dst,
    output logic                                gnt_excl,
    output logic [LINE_W-1:0]                   gnt_line
);
    localparam int SRC_W  = $clog2(NCACHE);
    localparam int BANK_W = $clog2(NBANK);

    logic [BANK_W-1:0] req_bank;
    logic [NBANK-1:0]  busy;
    logic [NBANK-1:0]  acc;
    logic [NBANK-1:0]  prb_req;
    logic [NBANK-1:0]  prb_take;
    logic [NBANK-1:0]  gnt_req;
    logic [NBANK-1:0]  gnt_take;
    logic [BANK_W-1:0] prb_idx;
    logic [BANK_W-1:0] gnt_idx;

    logic [NCACHE-1:0] b_prb_mask [NBANK];
    logic              b_prb_kind [NBANK];
    logic [LINE_W-1:0] b_prb_line [NBANK];
    logic [SRC_W-1:0]  b_gnt_src  [NBANK];
    logic              b_gnt_excl [NBANK];
    logic [LINE_W-1:0] b_gnt_line [NBANK];

    assign req_bank  = req_line[BANK_W-1:0];
    assign req_ready = !busy[req_bank];

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            assign acc[b] = req_valid && req_ready && (req_bank == BANK_W'(b));

            sdir_bank #(
                .NCACHE (NCACHE),
                .LINE_W (LINE_W),
                .BANK_W (BANK_W)
            ) u_bank (
                .clk       (clk),
                .rst       (rst),
                .acc       (acc[b]),
                .acc_src   (req_src),
                .acc_excl  (req_excl),
                .acc_line  (req_line),
                .busy      (busy[b]),
                .prb_req   (prb_req[b]),
                .prb_mask  (b_prb_mask[b]),
                .prb_kind  (b_prb_kind[b]),
                .prb_line  (b_prb_line[b]),
                .prb_take  (prb_take[b]),
                .ack_valid (ack_valid),
                .ack_line  (ack_line),
                .gnt_req   (gnt_req[b]),
                .gnt_src   (b_gnt_src[b]),
                .gnt_excl  (b_gnt_excl[b]),
                .gnt_line  (b_gnt_line[b]),
                .gnt_take  (gnt_take[b])
            );
        end
    endgenerate

    sdir_pick #(.N(NBANK)) u_prb_pick (
        .req (prb_req),
        .gnt (prb_take),
        .idx (prb_idx),
        .any (prb_valid)
    );

    sdir_pick #(.N(NBANK)) u_gnt_pick (
        .req (gnt_req),
        .gnt (gnt_take),
        .idx (gnt_idx),
        .any (gnt_valid)
    );

    assign prb_mask = b_prb_mask[prb_idx];
    assign prb_kind = b_prb_kind[prb_idx];
    assign prb_line = b_prb_line[prb_idx];
    assign gnt_dst  = b_gnt_src[gnt_idx];
    assign gnt_excl = b_gnt_excl[gnt_idx];
    assign gnt_line = b_gnt_line[gnt_idx];
endmodule

// File: rtl/sharer_directory_chk.sv
module sharer_directory_chk #(
    parameter int NCACHE = 4,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [BANK_W-1:0] req_bank,
    input logic              prb_valid,
    input logic              prb_kind,
    input logic [NCACHE-1:0] prb_mask,
    input logic              gnt_valid
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: first cycle out of reset is quiet and open
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> (!prb_valid && !gnt_valid && req_ready));

    // R3: a probe always names at least one cache
    p_mask_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        prb_valid |-> (prb_mask != '0));

    // R5: a downgrade goes to exactly one owner
    p_downgrade_single_r5: assert property (@(posedge clk) disable iff (rst)
        (prb_valid && prb_kind) |-> ($countones(prb_mask) == 1));

    // R7: a bank that just accepted cannot accept again on the next edge
    p_bank_locked_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=>
            !(req_valid && req_ready && (req_bank == $past(req_bank))));
endmodule

bind sharer_directory sharer_directory_chk #(
    .NCACHE (NCACHE),
    .BANK_W (BANK_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_bank  (req_line[BANK_W-1:0]),
    .prb_valid (prb_valid),
    .prb_kind  (prb_kind),
    .prb_mask  (prb_mask),
    .gnt_valid (gnt_valid)
);

// File: tb/sharer_directory_bench.sv
module sharer_directory_bench;
    localparam int NC = 4;
    localparam int NB = 4;
    localparam int LW = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [1:0]      req_src = '0;
    logic            req_excl = 1'b0;
    logic [LW-1:0]   req_line = '0;
    logic            prb_valid;
    logic            prb_kind;
    logic [NC-1:0]   prb_mask;
    logic [LW-1:0]   prb_line;
    logic [NC-1:0]   ack_valid = '0;
    logic [NC-1:0][LW-1:0] ack_line = '0;
    logic            gnt_valid;
    logic [1:0]      gnt_dst;
    logic            gnt_excl;
    logic [LW-1:0]   gnt_line;

    always #10 clk = ~clk;

    sharer_directory #(.NCACHE(NC), .NBANK(NB), .LINE_W(LW)) u_sharer_directory (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
        .req_excl(req_excl), .req_line(req_line),
        .prb_valid(prb_valid), .prb_kind(prb_kind), .prb_mask(prb_mask),
        .prb_line(prb_line),
        .ack_valid(ack_valid), .ack_line(ack_line),
        .gnt_valid(gnt_valid), .gnt_dst(gnt_dst), .gnt_excl(gnt_excl),
        .gnt_line(gnt_line)
    );

    typedef struct {
        int    a;
        int    b;
        int    line;
        string tag;
    } exp_t;

    exp_t exp_prb[$];
    exp_t exp_gnt[$];
    exp_t mon_e;

    int       n_chk = 0;
    int       n_bad = 0;
    bit       done  = 0;
    int       m_st  [64];
    bit [3:0] m_vec [64];

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Scoreboard monitor: compares every probe and grant with the queues
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (prb_valid) begin
                if (exp_prb.size() == 0) begin
                    chk(1'b0, "R3 unexpected probe", int'(prb_line), -1);
                end else begin
                    mon_e = exp_prb.pop_front();
                    chk(int'(prb_kind) == mon_e.a && int'(prb_mask) == mon_e.b
                        && int'(prb_line) == mon_e.line, mon_e.tag,
                        (int'(prb_kind) << 10) | (int'(prb_mask) << 6) | int'(prb_line),
                        (mon_e.a << 10) | (mon_e.b << 6) | mon_e.line);
                end
            end
            if (gnt_valid) begin
                if (exp_gnt.size() == 0) begin
                    chk(1'b0, "R2 unexpected grant", int'(gnt_line), -1);
                end else begin
                    mon_e = exp_gnt.pop_front();
                    chk(int'(gnt_dst) == mon_e.a && int'(gnt_excl) == mon_e.b
                        && int'(gnt_line) == mon_e.line, mon_e.tag,
                        (int'(gnt_dst) << 10) | (int'(gnt_excl) << 6) | int'(gnt_line),
                        (mon_e.a << 10) | (mon_e.b << 6) | mon_e.line);
                end
            end
        end
    end

    // Driver: computes expected traffic from the requirements, then issues
    task automatic request(input int src, input bit ex, input int line,
                           input bit push_gnt, input string tag);
        bit [3:0] sb;
        bit [3:0] tgt;
        int       kind;
        sb   = 4'(1 << src);
        kind = ex ? 0 : 1;
        if (ex) tgt = m_vec[line] & ~sb;
        else if (m_st[line] == 2) tgt = m_vec[line] & ~sb;
        else tgt = '0;
        if (tgt != 0) exp_prb.push_back('{kind, int'(tgt), line, tag});
        if (push_gnt) exp_gnt.push_back('{src, int'(ex), line, tag});
        if (ex) begin
            m_st[line]  = 2;
            m_vec[line] = sb;
        end else begin
            m_st[line]  = 1;
            m_vec[line] = m_vec[line] | sb;
        end
        req_valid = 1'b1;
        req_src   = 2'(src);
        req_excl  = ex;
        req_line  = 6'(line);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ack(input logic [3:0] m, input logic [3:0][5:0] ln);
        @(negedge clk);
        ack_valid = m;
        ack_line  = ln;
        @(negedge clk);
        ack_valid = '0;
    endtask

    task automatic ack1(input logic [3:0] m, input int line);
        ack(m, {4{6'(line)}});
    endtask

    task automatic peek_ready(input int line, output bit r);
        req_line = 6'(line);
        #1;
        r = req_ready;
    endtask

    task automatic run_tests();
        bit r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        peek_ready(0, r);
        chk(r, "R1 ready after reset", int'(r), 1);
        chk(!prb_valid && !gnt_valid, "R1 no traffic after reset",
            int'(prb_valid) + int'(gnt_valid), 0);

        // R2: miss on an Invalid line is granted at once
        request(0, 0, 5, 1, "R2 shared on invalid");
        chk(gnt_valid && gnt_line == 5 && !prb_valid, "R2 grant next cycle",
            int'(gnt_valid), 1);
        request(1, 0, 5, 1, "R2 shared on shared");
        chk(gnt_valid && gnt_dst == 1 && !prb_valid, "R2 second sharer granted",
            int'(gnt_valid), 1);

        // R3: exclusive invalidates other sharers only
        request(2, 1, 5, 0, "R3 invalidate sharers");
        chk(prb_valid && prb_mask == 4'b0011 && prb_kind == 1'b0, "R3 probe mask",
            int'(prb_mask), 3);
        // R7: bank 1 closed, bank 2 still accepts
        peek_ready(5, r);
        chk(!r, "R7 busy bank stalls", int'(r), 0);
        request(3, 0, 6, 1, "R7 other bank grant");
        chk(gnt_valid && gnt_line == 6, "R7 idle bank grants meanwhile",
            int'(gnt_line), 6);
        exp_gnt.push_back('{2, 1, 5, "R4 grant after acks"});
        ack1(4'b0001, 5);
        chk(!gnt_valid, "R4 grant withheld after partial acks", int'(gnt_valid), 0);
        ack1(4'b0010, 5);
        chk(gnt_valid && gnt_line == 5 && gnt_dst == 2, "R4 grant after last ack",
            int'(gnt_valid), 1);

        // R10: sole holder upgrades without probe
        request(3, 0, 9, 1, "R10 setup");
        request(3, 1, 9, 1, "R10 upgrade grant");
        chk(gnt_valid && !prb_valid && gnt_excl, "R10 no probe on upgrade",
            int'(prb_valid), 0);

        // R5 and R6: owner from the exclusive grant is downgraded
        request(0, 0, 5, 1, "R6 downgrade to owner");
        chk(prb_valid && prb_kind == 1'b1 && prb_mask == 4'b0100, "R6 owner is cache 2",
            int'(prb_mask), 4);
        ack1(4'b0100, 5);
        chk(gnt_valid && gnt_dst == 0, "R5 grant after writeback ack", int'(gnt_dst), 0);
        request(1, 1, 5, 1, "R5 both caches left as sharers");
        chk(prb_valid && prb_mask == 4'b0101, "R5 sharers are owner and reader",
            int'(prb_mask), 5);
        ack1(4'b0101, 5);
        chk(gnt_valid && gnt_dst == 1, "R4 simultaneous acks counted", int'(gnt_valid), 1);

        // R8: acknowledgement for another bank is ignored
        request(1, 0, 2, 1, "R8 setup");
        request(0, 1, 2, 1, "R8 probe");
        ack1(4'b0010, 3);
        chk(!gnt_valid, "R8 foreign-bank ack ignored", int'(gnt_valid), 0);
        peek_ready(2, r);
        chk(!r, "R8 bank still waiting", int'(r), 0);
        ack1(4'b0010, 2);
        chk(gnt_valid && gnt_line == 2, "R8 grant after own ack", int'(gnt_line), 2);

        // R9: two banks complete on one edge
        request(3, 0, 13, 1, "R9 setup a");
        request(2, 0, 14, 1, "R9 setup b");
        request(0, 1, 14, 0, "R9 probe bank 2");
        request(0, 1, 13, 0, "R9 probe bank 1");
        exp_gnt.push_back('{0, 1, 13, "R9 lower bank first"});
        exp_gnt.push_back('{0, 1, 14, "R9 higher bank next"});
        ack(4'b1100, {6'd13, 6'd14, 6'd0, 6'd0});
        chk(gnt_valid && gnt_line == 13, "R9 bank 1 grants first", int'(gnt_line), 13);
        @(negedge clk);
        chk(gnt_valid && gnt_line == 14, "R9 bank 2 grants next cycle",
            int'(gnt_line), 14);

        repeat (4) @(negedge clk);
        chk(exp_prb.size() == 0, "R3 all probes seen", exp_prb.size(), 0);
        chk(exp_gnt.size() == 0, "R2 all grants seen", exp_gnt.size(), 0);
    endtask

    initial begin
        bit wd;
        wd = 0;
        for (int i = 0; i < 64; i++) begin
            m_st[i]  = 0;
            m_vec[i] = '0;
        end
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                wd = 1;
            end
        join_any
        disable fork;
        done = 1;
        if (wd) chk(1'b0, "R1 watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule